// File: doc/BRIEF.md
# Event Interrupt Hub with Keyed Core Reset

This block sits next to a serial peripheral core and gathers that core's six event lines into one interrupt request. Each event line is watched for a low-to-high transition. A transition latches a sticky pending bit. Software polls the pending bits or lets them raise the interrupt. A per-source mask selects which pending bits may request an interrupt. A single master gate, held in the top bit of its own register, decides whether the combined request reaches the `irq_o` pin.

The same register window holds a reset register protected by a key. Only one exact 32-bit value written there starts a reset pulse towards the attached core. That pulse lasts a fixed number of cycles. Any other value is dropped silently. The hub's own registers are not touched by this pulse.

Access uses a plain strobe interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational decode of `bus_addr` and the current register contents. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `evt_irq_hub`

## Requirements
- R1: After synchronous reset, the pending bits, the mask bits, the master gate, `irq_o` and `core_rst_o` are all zero.
- R2: A 0-to-1 transition on `ev_i[k]` sets pending bit k, and the bit reads as 1 from the next cycle on. A line that stays high sets the bit only once. The bit order is: 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive FIFO full, 5 receive overrun.
- R3: Pending bits latch whether or not their mask bit is set, so they can be polled.
- R4: A write to offset 0x20 clears each pending bit whose data bit is 1 and leaves the others alone. Writing back a value just read from 0x20 therefore clears everything it showed. Reads of 0x20 return the pending bits in [5:0] and zero above.
- R5: If a rising event and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: Offset 0x28 holds the six mask bits in [5:0]. It is writable and readable, and its upper bits read as zero.
- R7: Offset 0x1C holds the master gate in bit 31. It is writable and readable, and all other bits read as zero.
- R8: `irq_o` is high exactly when the master gate is 1 and at least one pending bit has its mask bit set.
- R9: Writing exactly 0x0000000A to offset 0x40 drives `core_rst_o` high for PULSE_LEN cycles, starting in the cycle after the write.
- R10: Writing any other value to 0x40, or writing the key to any other offset, produces no pulse.
- R11: Reads of 0x40 and of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| ev_i | input | NUM_SRC | Event lines from the core |
| irq_o | output | 1 | Combined interrupt request |
| core_rst_o | output | 1 | Soft reset pulse to the core |

## Verification
The bench builds the hub with its default six sources and sets PULSE_LEN to 5, so that the pulse width is not confused with any other small constant. With six sources, all 64 pending patterns can be crossed with all 64 mask values, under both settings of the master gate. This checks the interrupt equation (R8) in every reachable state. The run-length count of the reset pulse and a set of near-miss keys and near-miss offsets then show that only the exact key at the exact offset starts a pulse.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned GATE_BIT = 31;
  localparam logic [7:0]  OFS_GATE = 8'h1C;
  localparam logic [7:0]  OFS_PEND = 8'h20;
  localparam logic [7:0]  OFS_MASK = 8'h28;
  localparam logic [7:0]  OFS_KRST = 8'h40;
  localparam logic [31:0] KRST_KEY = 32'h0000_000A;

  typedef struct packed {
    logic gate_we;
    logic pend_we;
    logic mask_we;
    logic krst_hit;
  } wr_dec_t;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] ev_d;
  logic [NUM_SRC-1:0] rise;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign rise[k] = ev_i[k] & ~ev_d[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        ev_d[k]   <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        ev_d[k] <= ev_i[k];
        // a fresh event beats a clear landing in the same cycle
        if (rise[k])
          pend_q[k] <= 1'b1;
        else if (clr_we && clr_mask[k])
          pend_q[k] <= 1'b0;
      end
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
      rise[k] |=> pend_q[k]);
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[k] && !rise[k]) |=> !pend_q[k]);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      (!rise[k] && !(clr_we && clr_mask[k])) |=> $stable(pend_q[k]));
    assert_setwins_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[k] && rise[k]) |=> pend_q[k]);
  end
endmodule

// File: rtl/krst_pulser.sv
module krst_pulser #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (fire)
      left_q <= CW'(PULSE_LEN);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  assert_start_R9: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse_o);
endmodule

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = REG_W,
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               gate_q,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] pend_q,
  output wr_dec_t            dec,
  output logic [DATA_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_GATE);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_KRST = ADDR_W'(OFS_KRST);

  always_comb begin
    dec.gate_we  = wr && (addr == A_GATE);
    dec.pend_we  = wr && (addr == A_PEND);
    dec.mask_we  = wr && (addr == A_MASK);
    dec.krst_hit = wr && (addr == A_KRST) && (wdata == DATA_W'(KRST_KEY));
  end

  always_comb begin
    rdata = '0;
    if (addr == A_GATE)
      rdata[GATE_BIT] = gate_q;
    else if (addr == A_PEND)
      rdata[NUM_SRC-1:0] = pend_q;
    else if (addr == A_MASK)
      rdata[NUM_SRC-1:0] = mask_q;
  end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = REG_W,
  parameter int unsigned NUM_SRC   = 6,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] ev_i,
  output logic               irq_o,
  output logic               core_rst_o
);
  wr_dec_t            dec;
  logic               gate_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend_q;

  evt_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .gate_q(gate_q), .mask_q(mask_q), .pend_q(pend_q),
    .dec(dec), .rdata(bus_rdata)
  );

  evt_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .ev_i(ev_i),
    .clr_we(dec.pend_we), .clr_mask(bus_wdata[NUM_SRC-1:0]),
    .pend_q(pend_q)
  );

  krst_pulser #(.PULSE_LEN(PULSE_LEN)) u_krst (
    .clk(clk), .rst(rst), .fire(dec.krst_hit), .pulse_o(core_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (dec.gate_we) gate_q <= bus_wdata[GATE_BIT];
      if (dec.mask_we) mask_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  assign irq_o = gate_q & (|(pend_q & mask_q));

  // checks
  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;
  always_ff @(posedge clk) begin
    if (rst_seen_q && !rst)
      assert_reset_R1: assert (pend_q == '0 && mask_q == '0 && !gate_q
                               && !irq_o && !core_rst_o);
  end

  assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (gate_q && (pend_q & mask_q) != '0));
  assert_src_R8: assert property (@(posedge clk) disable iff (rst)
    (gate_q && (pend_q & mask_q) != '0) |-> irq_o);
  assert_mask_wr_R6: assert property (@(posedge clk) disable iff (rst)
    dec.mask_we |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));
  assert_nokey_R10: assert property (@(posedge clk) disable iff (rst)
    (!core_rst_o && !dec.krst_hit) |=> !core_rst_o);
endmodule

// File: tb/evt_irq_hub_test.sv
`timescale 1ns/1ps
module evt_irq_hub_test;
  localparam int unsigned PL = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'hFC;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  ev_i = '0;
  logic        irq_o;
  logic        core_rst_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  evt_irq_hub #(.ADDR_W(8), .DATA_W(32), .NUM_SRC(6), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_i(ev_i),
    .irq_o(irq_o), .core_rst_o(core_rst_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'hFC; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 8'hFC;
  endtask

  task automatic load_pending(input logic [5:0] p);
    bus_write(8'h20, 32'h3F);
    ev_i = p;
    @(negedge clk);
    ev_i = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] snap;
    int len;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(8'h20, rd); check("R1 pending after reset", rd, 0);
    bus_read(8'h28, rd); check("R1 mask after reset", rd, 0);
    bus_read(8'h1C, rd); check("R1 gate after reset", rd, 0);
    check("R1 irq after reset", {31'd0, irq_o}, 0);
    check("R1 core_rst after reset", {31'd0, core_rst_o}, 0);
    @(negedge clk);

    // R2 each source sets its own bit
    for (int k = 0; k < 6; k++) begin
      ev_i = 6'(1 << k);
      @(negedge clk);
      bus_read(8'h20, rd); check($sformatf("R2 source %0d sets bit", k), rd, 32'(1 << k));
      ev_i = '0;
      bus_write(8'h20, rd);
      bus_read(8'h20, rd); check("R4 writeback clears", rd, 0);
    end

    // R2 held level sets once; R5 set wins over clear
    ev_i[2] = 1'b1; @(negedge clk);
    ev_i[2] = 1'b0; @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h04; ev_i[2] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'hFC; bus_wdata = '0;
    bus_read(8'h20, rd); check("R5 set wins over clear", rd, 32'h04);
    bus_write(8'h20, 32'h04);
    bus_read(8'h20, rd); check("R2 held level clear", rd, 0);
    repeat (3) @(negedge clk);
    bus_read(8'h20, rd); check("R2 held level does not reset", rd, 0);
    ev_i = '0; @(negedge clk);

    // R4 partial clear
    load_pending(6'h3F);
    bus_write(8'h20, 32'hFFFF_FF15);
    bus_read(8'h20, rd); check("R4 partial clear", rd, 32'h2A);

    // R3 pending latches with mask zero
    bus_write(8'h28, 32'h0);
    bus_write(8'h1C, 32'h8000_0000);
    load_pending(6'h20);
    bus_read(8'h20, rd); check("R3 latched while masked", rd, 32'h20);
    check("R3 masked gives no irq", {31'd0, irq_o}, 0);

    // R6 / R7 register widths
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_read(8'h28, rd); check("R6 mask readback", rd, 32'h3F);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_read(8'h1C, rd); check("R7 gate set readback", rd, 32'h8000_0000);
    bus_write(8'h1C, 32'h7FFF_FFFF);
    bus_read(8'h1C, rd); check("R7 gate cleared by bit31", rd, 0);

    // R8 exhaustive sweep
    for (int p = 0; p < 64; p++) begin
      load_pending(6'(p));
      bus_read(8'h20, rd); check("R2 pattern latch", rd, 32'(p));
      for (int g = 0; g < 2; g++) begin
        bus_write(8'h1C, g ? 32'h8000_0000 : 32'h0);
        for (int e = 0; e < 64; e++) begin
          bus_write(8'h28, 32'(e));
          check($sformatf("R8 irq p=%0d e=%0d g=%0d", p, e, g), {31'd0, irq_o},
                {31'd0, (g == 1) && ((p & e) != 0)});
        end
      end
    end

    // R9 key pulse width
    bus_write(8'h40, 32'h0000_000A);
    len = 0;
    while (core_rst_o && len < 20) begin len++; @(negedge clk); end
    check("R9 pulse length", 32'(len), PL);
    check("R9 pulse ends", {31'd0, core_rst_o}, 0);

    // R10 near-miss keys and offsets
    for (int i = 0; i < 6; i++) begin
      logic [31:0] bad;
      case (i)
        0: bad = 32'h0;         1: bad = 32'h0B;
        2: bad = 32'h1A;        3: bad = 32'h8000_000A;
        4: bad = 32'h0000_010A; default: bad = 32'h0A0A_0A0A;
      endcase
      bus_write(8'h40, bad);
      check("R10 wrong key no pulse", {31'd0, core_rst_o}, 0);
      @(negedge clk);
      check("R10 wrong key no pulse later", {31'd0, core_rst_o}, 0);
    end
    for (int i = 0; i < 3; i++) begin
      bus_write(i == 0 ? 8'h3C : (i == 1 ? 8'h41 : 8'h44), 32'h0A);
      check("R10 key at wrong offset", {31'd0, core_rst_o}, 0);
    end

    // R11 unmapped access
    load_pending(6'h09);
    bus_write(8'h28, 32'h15);
    bus_write(8'h1C, 32'h8000_0000);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_write(8'h2C, 32'hFFFF_FFFF);
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h20, snap); check("R11 pending untouched", snap, 32'h09);
    bus_read(8'h28, rd); check("R11 mask untouched", rd, 32'h15);
    bus_read(8'h1C, rd); check("R11 gate untouched", rd, 32'h8000_0000);
    bus_read(8'h24, rd); check("R11 unmapped reads zero", rd, 0);
    bus_read(8'h40, rd); check("R11 key register reads zero", rd, 0);
    check("R8 irq with overlap", {31'd0, irq_o}, 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule